// File: doc/BRIEF.md
# Dual-Wiper Serial Command Decoder

This block is the serial slave of a two-channel digital potentiometer controller. A host sends 16-bit frames on a four-wire serial port (active-low select, clock, data in, data out). Each frame carries a command, an address and a data byte. The block acts on two volatile 8-bit wiper registers and on sixteen bytes of modelled nonvolatile storage. Bytes 0 and 1 of that storage hold the saved settings of wipers 0 and 1.

The serial pins are oversampled in the system clock domain. A command runs only after select has returned high, and only if exactly sixteen clock edges arrived while select was low. The data-out line repeats the most recent sixteen bits clocked in, one frame later, so several devices can be daisy-chained on one select. After a read command, the low byte of that repeated word is replaced by the register that was read.

A write to storage keeps the storage busy for a fixed number of cycles, and frames that complete during that time do nothing. At reset, and on command, each wiper is reloaded from its saved byte.

Top module: `dpot_ctrl`

## Requirements
- R1: A frame is 16 bits, most significant bit first. Bits 15:12 are the command, bits 11:8 the address and bits 7:0 the data byte. Command 11 (4'hB) loads the data byte into the wiper selected by address bit 0.
- R2: No command changes any register while select is still low, even after all 16 bits have arrived. Execution follows the rising edge of select.
- R3: A select-low period with fewer or more than 16 rising serial clock edges executes nothing.
- R4: The data-out line presents, most significant bit first, the last 16 bits clocked in before the current frame. Data in is sampled on the rising serial clock edge, and data out changes on the falling edge.
- R5: The data-out enable is low while select is high and high while select is low.
- R6: Command 9 (4'h9) puts storage byte [address] into bits 7:0 of the word that is repeated out in the next frame. Command 10 (4'hA) does the same with the wiper selected by address bit 0.
- R7: Command 3 (4'h3) writes the data byte to storage byte [address]. Command 1 (4'h1) copies storage byte [address bit 0] into the wiper selected by address bit 0 and raises recall_mode. Command 0 (4'h0) clears recall_mode and changes nothing else.
- R8: Command 2 (4'h2) saves the wiper selected by address bit 0 into storage byte [address bit 0]. Command 8 (4'h8) reloads every wiper from its storage byte.
- R9: Storage starts at 8'h80 in every byte and keeps its contents through rst. By the fourth clock edge after rst falls, each wiper equals its storage byte.
- R10: A storage write (commands 2 and 3) holds nv_busy high for exactly NV_BUSY_CYCLES cycles. A frame that completes while nv_busy is high is ignored.
- R11: Command 14 (4'hE) adds one to the selected wiper and stops at 8'hFF. Command 6 (4'h6) subtracts one and stops at 8'h00. Commands 15 (4'hF) and 7 (4'h7) do the same to both wipers.
- R12: Command 4 (4'h4) halves the selected wiper (right shift). Command 12 (4'hC) doubles it (left shift), giving 8'hFF when bit 7 is set. Commands 5 (4'h5) and 13 (4'hD) apply the same to both wipers. None of these uses the data byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Drive enable for miso; the pad floats when low |
| wiper | output | NUM_WIPERS x DATA_W | Wiper register values |
| nv_busy | output | 1 | Storage write in progress |
| recall_mode | output | 1 | Set by command 1, cleared by command 0 |

## Verification
Every serial pin passes two synchronizer flops and an edge-detect register. As a result:
- A frame is accepted on the third clock edge after select rises.
- Wiper, readback and busy results land on the fifth edge.
- A command-8 reload is done by about the eighth edge.
- Data out moves on the third edge after the serial clock falls.

The bench holds each serial half period for eight clocks. It samples data out just before raising the serial clock. It checks register state sixteen clocks after select rises, and it checks the wipers once more just before select rises, to catch early execution. Its model decides whether a frame is ignored from the cycle distance to the last storage write, and the busy test keeps far from that boundary. The length of the busy pulse is counted separately, cycle by cycle.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int CMD_W = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP      = 4'h0,
    CMD_RECALL   = 4'h1,
    CMD_SAVE     = 4'h2,
    CMD_NV_WRITE = 4'h3,
    CMD_HALF_ONE = 4'h4,
    CMD_HALF_ALL = 4'h5,
    CMD_DEC_ONE  = 4'h6,
    CMD_DEC_ALL  = 4'h7,
    CMD_RELOAD   = 4'h8,
    CMD_RD_NV    = 4'h9,
    CMD_RD_WIPER = 4'hA,
    CMD_WR_WIPER = 4'hB,
    CMD_DBL_ONE  = 4'hC,
    CMD_DBL_ALL  = 4'hD,
    CMD_INC_ONE  = 4'hE,
    CMD_INC_ALL  = 4'hF
  } cmd_e;

  typedef enum logic [1:0] {
    S_LOAD_RD,
    S_LOAD_WR,
    S_IDLE,
    S_APPLY
  } exec_state_e;
endpackage

// File: rtl/dpot_nvmem.sv
module dpot_nvmem #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter logic [DW-1:0] INIT = 8'h80
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = INIT;
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/dpot_spi_front.sv
module dpot_spi_front #(
  parameter int FRAME_W = 16,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               mosi,
  input  logic               rb_load,
  input  logic [DATA_W-1:0]  rb_byte,
  output logic               frame_valid,
  output logic [FRAME_W-1:0] frame_word,
  output logic               miso,
  output logic               miso_oe
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic [1:0]         cs_sync, sclk_sync, mosi_sync;
  logic               cs_d, sclk_d;
  logic               cs_s, sclk_s, mosi_s;
  logic               cs_fall, cs_rise, sclk_rise, sclk_fall;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   bit_cnt;

  assign cs_s      = cs_sync[1];
  assign sclk_s    = sclk_sync[1];
  assign mosi_s    = mosi_sync[1];
  assign cs_fall   = cs_d & ~cs_s;
  assign cs_rise   = ~cs_d & cs_s;
  assign sclk_rise = sclk_s & ~sclk_d & ~cs_s;
  assign sclk_fall = ~sclk_s & sclk_d & ~cs_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_sync     <= 2'b11;
      sclk_sync   <= 2'b00;
      mosi_sync   <= 2'b00;
      cs_d        <= 1'b1;
      sclk_d      <= 1'b0;
      shreg       <= '0;
      bit_cnt     <= '0;
      frame_valid <= 1'b0;
      frame_word  <= '0;
      miso        <= 1'b0;
      miso_oe     <= 1'b0;
    end else begin
      cs_sync     <= {cs_sync[0], cs_n};
      sclk_sync   <= {sclk_sync[0], sclk};
      mosi_sync   <= {mosi_sync[0], mosi};
      cs_d        <= cs_s;
      sclk_d      <= sclk_s;
      miso_oe     <= ~cs_s;
      frame_valid <= cs_rise && (bit_cnt == CNT_FULL);
      if (cs_rise) frame_word <= shreg;

      if (cs_fall) bit_cnt <= '0;
      else if (sclk_rise && bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;

      if (sclk_rise) shreg <= {shreg[FRAME_W-2:0], mosi_s};
      else if (rb_load) shreg[DATA_W-1:0] <= rb_byte;

      if (cs_fall || sclk_fall) miso <= shreg[FRAME_W-1];
    end
  end

  // R5
  oe_off_at_exec_chk: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> !miso_oe)
    else $error("data out driven while a frame is handed over");

  // R4
  miso_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(sclk_fall || cs_fall) |=> $stable(miso))
    else $error("data out moved away from a falling serial edge");
endmodule

// File: rtl/dpot_exec.sv
module dpot_exec
  import dpot_pkg::*;
#(
  parameter int NW          = 2,
  parameter int DW          = 8,
  parameter int AW          = 4,
  parameter int BUSY_CYCLES = 64,
  parameter int FRAME_W     = CMD_W + AW + DW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_valid,
  input  logic [FRAME_W-1:0]  frame_word,
  output logic [AW-1:0]       mem_addr,
  output logic                mem_we,
  output logic [DW-1:0]       mem_wdata,
  input  logic [DW-1:0]       mem_rdata,
  output logic [NW-1:0][DW-1:0] wiper,
  output logic                nv_busy,
  output logic                recall_mode,
  output logic                rb_load,
  output logic [DW-1:0]       rb_byte
);
  localparam int SEL_W  = (NW > 1) ? $clog2(NW) : 1;
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(NW - 1);

  exec_state_e       state;
  cmd_e              cmd_q, f_cmd;
  logic [AW-1:0]     addr_q, f_addr;
  logic [DW-1:0]     data_q;
  logic [SEL_W-1:0]  sel_q, f_sel, idx;
  logic [BUSY_W-1:0] busy_cnt;
  logic              accept, all_q;

  assign f_cmd  = cmd_e'(frame_word[FRAME_W-1 -: CMD_W]);
  assign f_addr = frame_word[DW +: AW];
  assign f_sel  = f_addr[SEL_W-1:0];
  assign accept = (state == S_IDLE) && frame_valid && !nv_busy;
  assign all_q  = (cmd_q == CMD_HALF_ALL) || (cmd_q == CMD_DEC_ALL) ||
                  (cmd_q == CMD_DBL_ALL)  || (cmd_q == CMD_INC_ALL);

  function automatic logic [DW-1:0] adjust(input logic [DW-1:0] v, input cmd_e op);
    case (op)
      CMD_HALF_ONE, CMD_HALF_ALL: adjust = v >> 1;
      CMD_DEC_ONE,  CMD_DEC_ALL:  adjust = (v == '0) ? v : v - 1'b1;
      CMD_DBL_ONE,  CMD_DBL_ALL:  adjust = v[DW-1] ? '1 : {v[DW-2:0], 1'b0};
      CMD_INC_ONE,  CMD_INC_ALL:  adjust = (&v) ? v : v + 1'b1;
      default:                    adjust = v;
    endcase
  endfunction

  always_comb begin
    case (state)
      S_LOAD_RD: mem_addr = AW'(idx);
      S_IDLE:    mem_addr = (f_cmd == CMD_RECALL) ? AW'(f_sel) : f_addr;
      S_APPLY:   mem_addr = (cmd_q == CMD_SAVE) ? AW'(sel_q) : addr_q;
      default:   mem_addr = '0;
    endcase
  end

  assign mem_we    = (state == S_APPLY) && (cmd_q == CMD_SAVE || cmd_q == CMD_NV_WRITE);
  assign mem_wdata = (cmd_q == CMD_SAVE) ? wiper[sel_q] : data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_LOAD_RD;
      idx         <= '0;
      wiper       <= '0;
      cmd_q       <= CMD_NOP;
      addr_q      <= '0;
      data_q      <= '0;
      sel_q       <= '0;
      busy_cnt    <= '0;
      nv_busy     <= 1'b0;
      recall_mode <= 1'b0;
      rb_load     <= 1'b0;
      rb_byte     <= '0;
    end else begin
      rb_load <= 1'b0;

      if (mem_we) begin
        busy_cnt <= BUSY_W'(BUSY_CYCLES);
        nv_busy  <= 1'b1;
      end else if (busy_cnt != '0) begin
        busy_cnt <= busy_cnt - 1'b1;
        nv_busy  <= (busy_cnt != BUSY_W'(1));
      end

      case (state)
        S_LOAD_RD: state <= S_LOAD_WR;
        S_LOAD_WR: begin
          wiper[idx] <= mem_rdata;
          if (idx == LAST_IDX) state <= S_IDLE;
          else begin
            idx   <= idx + 1'b1;
            state <= S_LOAD_RD;
          end
        end
        S_IDLE: begin
          if (accept) begin
            cmd_q  <= f_cmd;
            addr_q <= f_addr;
            data_q <= frame_word[DW-1:0];
            sel_q  <= f_sel;
            if (f_cmd == CMD_RELOAD) begin
              idx   <= '0;
              state <= S_LOAD_RD;
            end else begin
              state <= S_APPLY;
            end
          end
        end
        S_APPLY: begin
          state <= S_IDLE;
          case (cmd_q)
            CMD_NOP:      recall_mode <= 1'b0;
            CMD_RECALL: begin
              wiper[sel_q] <= mem_rdata;
              recall_mode  <= 1'b1;
            end
            CMD_RD_NV: begin
              rb_load <= 1'b1;
              rb_byte <= mem_rdata;
            end
            CMD_RD_WIPER: begin
              rb_load <= 1'b1;
              rb_byte <= wiper[sel_q];
            end
            CMD_WR_WIPER: wiper[sel_q] <= data_q;
            CMD_HALF_ONE, CMD_HALF_ALL, CMD_DEC_ONE, CMD_DEC_ALL,
            CMD_DBL_ONE, CMD_DBL_ALL, CMD_INC_ONE, CMD_INC_ALL: begin
              for (int i = 0; i < NW; i++) begin
                if (all_q || SEL_W'(i) == sel_q) wiper[i] <= adjust(wiper[i], cmd_q);
              end
            end
            default: ;
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && frame_valid && nv_busy) |=> (state == S_IDLE))
    else $error("frame acted on while storage busy");

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_cnt > BUSY_W'(1)) |=> nv_busy)
    else $error("busy flag dropped early");

  // R9
  restore_first_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state == S_LOAD_RD))
    else $error("reset did not start the wiper restore");

  // R6
  readback_src_chk: assert property (@(posedge clk) disable iff (rst)
    rb_load |-> ($past(state) == S_APPLY))
    else $error("readback load outside command execution");
endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
  import dpot_pkg::*;
#(
  parameter int NUM_WIPERS     = 2,
  parameter int DATA_W         = 8,
  parameter int ADDR_W         = 4,
  parameter int NV_BUSY_CYCLES = 64,
  parameter logic [DATA_W-1:0] NV_INIT = 8'h80
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               cs_n,
  input  logic                               sclk,
  input  logic                               mosi,
  output logic                               miso,
  output logic                               miso_oe,
  output logic [NUM_WIPERS-1:0][DATA_W-1:0]  wiper,
  output logic                               nv_busy,
  output logic                               recall_mode
);
  localparam int FRAME_W = CMD_W + ADDR_W + DATA_W;

  logic               frame_valid, rb_load, mem_we;
  logic [FRAME_W-1:0] frame_word;
  logic [DATA_W-1:0]  rb_byte, mem_wdata, mem_rdata;
  logic [ADDR_W-1:0]  mem_addr;

  dpot_spi_front #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_front (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .rb_load(rb_load), .rb_byte(rb_byte),
    .frame_valid(frame_valid), .frame_word(frame_word),
    .miso(miso), .miso_oe(miso_oe)
  );

  dpot_exec #(
    .NW(NUM_WIPERS), .DW(DATA_W), .AW(ADDR_W),
    .BUSY_CYCLES(NV_BUSY_CYCLES), .FRAME_W(FRAME_W)
  ) u_exec (
    .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame_word(frame_word),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .wiper(wiper), .nv_busy(nv_busy), .recall_mode(recall_mode),
    .rb_load(rb_load), .rb_byte(rb_byte)
  );

  dpot_nvmem #(.AW(ADDR_W), .DW(DATA_W), .INIT(NV_INIT)) u_nv (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata), .rdata(mem_rdata)
  );
endmodule

// File: tb/tb_dpot_ctrl.sv
module tb_dpot_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int BUSY       = 400;

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso, miso_oe, nv_busy, recall_mode;
  logic [1:0][7:0] wiper;

  int checks = 0, errors = 0;
  int cyc = 0, busy_seen = 0;
  logic busy_clr = 1'b0;
  bit done = 1'b0;

  int m_nv[16];
  int m_w[2];
  bit m_rp;
  int m_echo;
  int wr_cyc;

  dpot_ctrl #(.NV_BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .wiper(wiper),
    .nv_busy(nv_busy), .recall_mode(recall_mode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (busy_clr) busy_seen <= 0;
    else if (nv_busy) busy_seen <= busy_seen + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    chk(wiper[0] == m_w[0][7:0], {tag, " wiper0"}, int'(wiper[0]), m_w[0]);
    chk(wiper[1] == m_w[1][7:0], {tag, " wiper1"}, int'(wiper[1]), m_w[1]);
    chk(recall_mode == m_rp, {tag, " recall_mode"}, int'(recall_mode), int'(m_rp));
  endtask

  function automatic int dbl(input int v);
    return (v >= 128) ? 255 : v * 2;
  endfunction

  task automatic model_exec(input logic [15:0] w);
    int c, a, d, s;
    c = w[15:12]; a = w[11:8]; d = w[7:0]; s = a % 2;
    case (c)
      0:  m_rp = 0;
      1:  begin m_w[s] = m_nv[s]; m_rp = 1; end
      2:  begin m_nv[s] = m_w[s]; wr_cyc = cyc; end
      3:  begin m_nv[a] = d; wr_cyc = cyc; end
      4:  m_w[s] = m_w[s] / 2;
      5:  for (int i = 0; i < 2; i++) m_w[i] = m_w[i] / 2;
      6:  if (m_w[s] > 0) m_w[s]--;
      7:  for (int i = 0; i < 2; i++) if (m_w[i] > 0) m_w[i]--;
      8:  for (int i = 0; i < 2; i++) m_w[i] = m_nv[i];
      9:  m_echo = (m_echo & 'hFF00) | m_nv[a];
      10: m_echo = (m_echo & 'hFF00) | m_w[s];
      11: m_w[s] = d;
      12: m_w[s] = dbl(m_w[s]);
      13: for (int i = 0; i < 2; i++) m_w[i] = dbl(m_w[i]);
      14: if (m_w[s] < 255) m_w[s]++;
      default: for (int i = 0; i < 2; i++) if (m_w[i] < 255) m_w[i]++;
    endcase
  endtask

  // Sends nbits bits, MSB first; checks echo (R4), pre-release state (R2), enable (R5).
  task automatic send(input logic [16:0] bits, input int nbits, input string tag);
    int bad = 0, got = 0, want = 0, rise;
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    chk(miso_oe == 1'b1, "R5 enable during frame", int'(miso_oe), 1);
    for (int i = 0; i < nbits; i++) begin
      mosi = bits[nbits-1-i];
      repeat (HALF) @(negedge clk);
      if (miso != m_echo[15] && bad == 0) begin got = int'(miso); want = m_echo[15]; end
      if (miso != m_echo[15]) bad++;
      m_echo = ((m_echo << 1) | int'(bits[nbits-1-i])) & 'hFFFF;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    chk(bad == 0, {"R4 ", tag, " echo bits"}, got, want);
    repeat (HALF) @(negedge clk);
    chk(wiper[0] == m_w[0][7:0] && wiper[1] == m_w[1][7:0], "R2 no change before release",
        int'(wiper), m_w[1] * 256 + m_w[0]);
    cs_n = 1'b1;
    rise = cyc;
    repeat (16) @(negedge clk);
    if (nbits == 16 && (rise - wr_cyc) > BUSY + 2) model_exec(bits[15:0]);
    chk(miso_oe == 1'b0, "R5 enable idle", int'(miso_oe), 0);
    check_state(tag);
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_w[0] = m_nv[0]; m_w[1] = m_nv[1];
    m_rp = 0; m_echo = 0; wr_cyc = -100000;
    repeat (8) @(negedge clk);
    check_state("R9 restore");
    chk(nv_busy == 1'b0, "R9 busy clear", int'(nv_busy), 0);
    chk(miso_oe == 1'b0, "R5 reset enable", int'(miso_oe), 0);
  endtask

  task automatic nv_settle();
    repeat (BUSY + 20) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_nv[i] = 'h80;
    m_w[0] = 0; m_w[1] = 0; m_rp = 0; m_echo = 0; wr_cyc = -100000;
    do_reset();
    chk(wiper[0] == 8'h80, "R9 initial storage", int'(wiper[0]), 'h80);

    // R1 wiper writes
    send({1'b0, 16'hB03C}, 16, "R1 write w0");
    send({1'b0, 16'hB1A5}, 16, "R1 write w1");
    // R6 wiper readback, seen in next frame's echo
    send({1'b0, 16'hA000}, 16, "R6 read w0");
    send({1'b0, 16'h0000}, 16, "R6 readback echo");
    // R3 wrong lengths
    send({2'b0, 15'h3011}, 15, "R3 short frame");
    send({1'b0, 16'hB011}, 17, "R3 long frame");
    // R7 storage write, storage readback, recall and nop
    send({1'b0, 16'h3577}, 16, "R7 write nv5");
    nv_settle();
    send({1'b0, 16'h9500}, 16, "R6 read nv5");
    send({1'b0, 16'h0000}, 16, "R6 nv readback echo");
    send({1'b0, 16'h3042}, 16, "R7 write nv0");
    nv_settle();
    send({1'b0, 16'h1000}, 16, "R7 recall w0");
    send({1'b0, 16'h0000}, 16, "R7 nop clears recall");
    // R8 save and reload
    send({1'b0, 16'hB110}, 16, "R8 set w1");
    send({1'b0, 16'h2100}, 16, "R8 save w1");
    nv_settle();
    send({1'b0, 16'hB199}, 16, "R8 scribble w1");
    send({1'b0, 16'hB001}, 16, "R8 scribble w0");
    send({1'b0, 16'h8000}, 16, "R8 reload all");
    // R11 steps with saturation
    send({1'b0, 16'hB0FE}, 16, "R11 setup");
    send({1'b0, 16'hE000}, 16, "R11 inc to top");
    send({1'b0, 16'hE000}, 16, "R11 inc saturates");
    send({1'b0, 16'hB101}, 16, "R11 setup w1");
    send({1'b0, 16'h6100}, 16, "R11 dec to zero");
    send({1'b0, 16'h6100}, 16, "R11 dec saturates");
    send({1'b0, 16'hF000}, 16, "R11 inc all");
    send({1'b0, 16'h7000}, 16, "R11 dec all");
    // R12 halving and doubling
    send({1'b0, 16'hB0C1}, 16, "R12 setup");
    send({1'b0, 16'h40FF}, 16, "R12 halve ignores data");
    send({1'b0, 16'hC000}, 16, "R12 double");
    send({1'b0, 16'hC000}, 16, "R12 double saturates");
    send({1'b0, 16'hB103}, 16, "R12 setup w1");
    send({1'b0, 16'hD000}, 16, "R12 double all");
    send({1'b0, 16'h5000}, 16, "R12 halve all");
    // R10 busy window
    busy_clr = 1'b1;
    @(negedge clk) busy_clr = 1'b0;
    send({1'b0, 16'h3255}, 16, "R10 write nv2");
    send({1'b0, 16'hB05A}, 16, "R10 ignored while busy");
    chk(nv_busy == 1'b1, "R10 busy high", int'(nv_busy), 1);
    nv_settle();
    chk(nv_busy == 1'b0, "R10 busy released", int'(nv_busy), 0);
    chk(busy_seen == BUSY, "R10 busy length", busy_seen, BUSY);
    send({1'b0, 16'h9200}, 16, "R10 read nv2");
    send({1'b0, 16'hB05A}, 16, "R10 accepted after busy");
    // R9 storage survives reset
    do_reset();
    chk(wiper[0] == 8'h42 && wiper[1] == 8'h10, "R9 restore saved", int'(wiper), 'h1042);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule